// File: doc/BRIEF.md
# SPI Master Serial-Clock Rate Generator

This block derives the serial clock of an SPI master from the bus clock. Two counters run in cascade: a linear prescaler that divides by one of eight values from 1 to 8, and a binary divider that turns the prescaled strobe into a half-period tick. The full SCK period is therefore the prescale factor times a power of two between 2 and 256. The fastest setting gives half the bus rate.

A one-cycle start request launches one 8-bit frame. The generator then emits exactly sixteen half-period ticks, toggling SCK on each, and returns to idle on its own. Between frames SCK rests at the polarity level. The two rate selects are captured when a frame starts, so a change during a frame waits for the next one. With the enable low or with the block not in master mode, the generator does nothing: start is refused and any frame under way is dropped.

Top module: `spi_brg`

## Requirements
- R1: After reset `busy` and `half_tick` are 0 and `sck` equals `cpol`.
- R2: Whenever `busy` is 0, `sck` equals the current `cpol`.
- R3: With the prescale select at value p and the divider select at value d, each half period lasts (p+1)·2^d bus cycles. The first `half_tick` appears one half period after the edge that accepts `start`. For example, p=4 and d=3 give 40 cycles, which is a 0.25 MHz SCK from a 20 MHz bus.
- R4: One accepted start produces exactly 16 `half_tick` pulses. `busy` falls at the edge that raises the 16th pulse, and no further tick follows.
- R5: `sck` toggles at every clock edge that raises `half_tick`, and ends a frame back at `cpol`.
- R6: Changes on `presc_sel` or `div_sel` while `busy` is 1 do not alter the current frame's timing.
- R7: While `master` is 0, `start` is ignored. Clearing `master` during a frame ends the frame at the next edge, with `busy` at 0 and `sck` at `cpol`.
- R8: `en` at 0 has the same effect as `master` at 0.
- R9: A `start` pulse during a busy frame neither restarts nor lengthens it.
- R10: With both selects at 0, ticks come on every cycle and a frame lasts 16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Generator enable |
| master | input | 1 | 1 = master mode; 0 holds the generator idle |
| cpol | input | 1 | SCK idle level |
| presc_sel | input | 3 | Prescale select p, divide by p+1 |
| div_sel | input | 3 | Divider select d, full-period divide by 2^(d+1) |
| start | input | 1 | One-cycle request to begin a frame |
| busy | output | 1 | Frame in progress |
| half_tick | output | 1 | One-cycle pulse in the cycle after each SCK edge |
| sck | output | 1 | Serial clock |

## Verification
A wrong prescaler or divider count shows up as a first tick placed away from cycle (p+1)·2^d after start. The reference model flags this in that very cycle. A wrong tick counter shows up as a frame that ends early or late, seen at the 16th half period through `busy` and `sck`. A lost phase bit leaves `sck` away from `cpol` while idle, and this shows within one cycle. Selects captured at the wrong time, or a mode drop that is not obeyed, change the spacing of the next tick or `busy` on the following edge.

// File: rtl/spi_brg_pkg.sv
package spi_brg_pkg;
    localparam int BRG_SEL_W      = 3;
    localparam int BRG_FRAME_BITS = 8;
endpackage

// File: rtl/spi_brg_prescaler.sv
module spi_brg_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             stb
);
    logic [SEL_W-1:0] cnt_d, cnt_q;

    assign stb = run && (cnt_q == sel);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (run)
            cnt_d = stb ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q <= sel); // R3
endmodule

// File: rtl/spi_brg_divider.sv
module spi_brg_divider #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = (1 << SEL_W) - 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last;

    assign last = ~({CW{1'b1}} << sel);
    assign tick = adv && (cnt_q == last);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (adv)
            cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> cnt_q <= last); // R3
endmodule

// File: rtl/spi_brg.sv
module spi_brg
    import spi_brg_pkg::*;
#(
    parameter int SEL_W      = BRG_SEL_W,
    parameter int FRAME_BITS = BRG_FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             master,
    input  logic             cpol,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             start,
    output logic             busy,
    output logic             half_tick,
    output logic             sck
);
    localparam int TICKS = 2 * FRAME_BITS;
    localparam int TCW   = $clog2(TICKS + 1);

    typedef struct packed {
        logic             busy;
        logic             phase;
        logic             tick;
        logic [TCW-1:0]   nticks;
        logic [SEL_W-1:0] psel;
        logic [SEL_W-1:0] dsel;
    } brg_state_t;

    brg_state_t st_d, st_q;
    logic active, pre_stb, div_tick;

    assign active = en && master;

    spi_brg_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!st_q.busy),
        .run   (st_q.busy),
        .sel   (st_q.psel),
        .stb   (pre_stb)
    );

    spi_brg_divider #(.SEL_W(SEL_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!st_q.busy),
        .adv   (pre_stb),
        .sel   (st_q.dsel),
        .tick  (div_tick)
    );

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!active) begin
            st_d.busy   = 1'b0;
            st_d.phase  = 1'b0;
            st_d.nticks = '0;
        end else if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.phase  = 1'b0;
                st_d.nticks = '0;
                st_d.psel   = presc_sel;
                st_d.dsel   = div_sel;
            end
        end else if (div_tick) begin
            st_d.tick   = 1'b1;
            st_d.phase  = ~st_q.phase;
            st_d.nticks = st_q.nticks + 1'b1;
            if (st_q.nticks == TCW'(TICKS - 1))
                st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign half_tick = st_q.tick;
    assign sck       = cpol ^ st_q.phase;

    AST_TICK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |-> $past(st_q.busy)); // R4
    AST_TICK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.nticks <= TCW'(TICKS)); // R4
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> sck == cpol); // R2
    AST_MODE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !st_q.busy); // R7
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |-> ($stable(st_q.psel) && $stable(st_q.dsel))); // R6
endmodule

// File: tb/tb_spi_brg.sv
module tb_spi_brg;
    logic       clk = 1'b0;
    logic       rst_n, en, master, cpol, start;
    logic [2:0] presc_sel, div_sel;
    logic       busy, half_tick, sck;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    spi_brg dut (
        .clk(clk), .rst_n(rst_n), .en(en), .master(master), .cpol(cpol),
        .presc_sel(presc_sel), .div_sel(div_sel), .start(start),
        .busy(busy), .half_tick(half_tick), .sck(sck)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: cycles counted since the accepting edge
    int m_busy = 0, m_phase = 0, m_tick = 0, m_cnt = 0, m_half = 1, m_ticks = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_phase = 0; m_tick = 0; m_ticks = 0;
        end else if (!(en && master)) begin
            m_busy = 0; m_phase = 0; m_tick = 0; m_ticks = 0;
        end else if (m_busy == 0) begin
            m_tick = 0;
            if (start) begin
                m_busy = 1; m_phase = 0; m_cnt = 0; m_ticks = 0;
                m_half = (int'(presc_sel) + 1) << int'(div_sel);
            end
        end else begin
            m_cnt++;
            if (m_cnt == m_half) begin
                m_cnt = 0; m_tick = 1; m_phase ^= 1; m_ticks++;
                if (m_ticks == 16) m_busy = 0;
            end else begin
                m_tick = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(busy == m_busy[0], "R4 busy vs model", busy, m_busy);
            chk(half_tick == m_tick[0], "R3 half_tick vs model", half_tick, m_tick);
            chk(sck == (cpol ^ m_phase[0]), "R5 sck vs model", sck, cpol ^ m_phase[0]);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic xfer(input int p, input int d, input logic pol, input int chg_at,
                        input int rs_at, input int exp_first, input int exp_len);
        int first = -1;
        int nt = 0;
        int len = 0;
        presc_sel = 3'(p); div_sel = 3'(d); cpol = pol; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy && len < 20000) begin
            if (half_tick) begin
                if (first < 0) first = len;
                nt++;
            end
            if (len == chg_at) begin
                presc_sel = ~presc_sel; div_sel = ~div_sel;
            end
            start = (len == rs_at);
            @(negedge clk);
            len++;
        end
        start = 1'b0;
        if (half_tick) nt++;
        chk(first == exp_first, "R3 first tick delay", first, exp_first);
        chk(nt == 16, "R4 ticks per frame", nt, 16);
        chk(len == exp_len, "R4 frame length", len, exp_len);
        chk(sck == pol, "R5 sck back at idle", sck, pol);
        @(negedge clk);
        chk(half_tick == 1'b0, "R4 no tick after frame", half_tick, 0);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0; master = 1'b0; cpol = 1'b1; start = 1'b0;
        presc_sel = '0; div_sel = '0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy at reset", busy, 0);
        chk(half_tick == 1'b0, "R1 tick at reset", half_tick, 0);
        chk(sck == 1'b1, "R1 sck at reset", sck, 1);
        rst_n = 1'b1; en = 1'b1; master = 1'b1;
        @(negedge clk);

        xfer(0, 0, 1'b0, -1, -1, 1, 16);          // R10 fastest
        xfer(4, 3, 1'b1, -1, -1, 40, 640);        // R3 worked check
        xfer(7, 0, 1'b0, -1, -1, 8, 128);         // R3
        xfer(2, 5, 1'b1, -1, -1, 96, 1536);       // R3
        xfer(1, 1, 1'b0, 2, -1, 4, 64);           // R6 selects changed mid-frame
        xfer(1, 2, 1'b1, -1, 10, 8, 128);         // R9 start while busy

        cpol = 1'b0; #1;
        chk(sck == 1'b0, "R2 idle sck follows cpol", sck, 0);
        cpol = 1'b1; #1;
        chk(sck == 1'b1, "R2 idle sck follows cpol", sck, 1);
        @(negedge clk);

        master = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            chk(busy == 1'b0 && half_tick == 1'b0, "R7 slave ignores start", busy, 0);
            @(negedge clk);
        end
        master = 1'b1;
        presc_sel = 3'd0; div_sel = 3'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        master = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R7 abort on master drop", busy, 0);
        chk(sck == cpol, "R7 sck idle after abort", sck, cpol);
        master = 1'b1;
        @(negedge clk);

        en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R8 disabled ignores start", busy, 0);
        en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R8 abort on disable", busy, 0);
        en = 1'b1;
        @(negedge clk);

        xfer(7, 7, 1'b0, -1, -1, 1024, 16384);    // R3 slowest

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule